// File: doc/BRIEF.md
# Integer Divide and Remainder Unit

This block computes the quotient or the remainder of two 64-bit integers, signed or unsigned, and also offers a 32-bit word mode whose result is always sign-extended to 64 bits. A caller presents both operands, a 2-bit function select and a word-mode flag, and pulses `startIn` while the unit is idle. After a fixed number of cycles, `doneOut` pulses for one cycle and `resultOut` carries the answer.

Division never traps. A zero divisor and the one signed overflow case (the most negative value divided by minus one) each give a fixed result. The unit detects these cases at the start and finishes them in a single cycle. All other operations run through a shift-and-subtract loop on the operand magnitudes. The loop takes one step per result bit, so it runs 64 steps in full mode and 32 in word mode. A sign correction follows the loop.

Top module: `div_rem_unit`

## Requirements
- R1: With `funcSel` = 2'b00 (signed quotient), the quotient is truncated toward zero. For example, -100 / 7 gives -14 and 100 / -7 gives -14.
- R2: With `funcSel` = 2'b01 (unsigned quotient) and 2'b11 (unsigned remainder), both operands are treated as unsigned 64-bit values.
- R3: With `funcSel` = 2'b10 (signed remainder), the remainder has the sign of the dividend. For example, -100 rem 7 gives -2 and 100 rem -7 gives 2.
- R4: A divisor of zero gives an all-ones quotient in both the signed and the unsigned forms.
- R5: A divisor of zero gives a remainder equal to the dividend.
- R6: A signed divide of the most negative value by -1 gives that same most negative value as the quotient and zero as the remainder.
- R7: When `wordMode` is 1, only bits 31:0 of each operand are used. Bits 63:32 have no effect on the result.
- R8: In word mode, every result is the 32-bit answer sign-extended from bit 31. This covers the unsigned forms and the special cases. A zero divisor with an unsigned remainder returns the dividend's low word sign-extended. The word overflow case returns 0xFFFFFFFF80000000.
- R9: For a special case (zero divisor, or signed overflow), `doneOut` rises at the same clock edge that accepts the start. For any other operation, `doneOut` rises 65 edges after the accepting edge in full mode and 33 edges after it in word mode.
- R10: `doneOut` is high for exactly one cycle. `busyOut` is high from the accepting edge through the done cycle. A start that arrives while `busyOut` is high is ignored: it produces no result and no done pulse.
- R11: After reset, `busyOut`, `doneOut` and `resultOut` are all zero.
- R12: `resultOut` holds its value after the done pulse until a later operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Request a new operation; taken only when `busyOut` is low |
| funcSel | input | 2 | Function select: bit 1 = 1 chooses remainder, bit 0 = 1 chooses unsigned |
| wordMode | input | 1 | 1 selects a 32-bit operation with a sign-extended result |
| dividendIn | input | 64 | Dividend operand |
| divisorIn | input | 64 | Divisor operand |
| busyOut | output | 1 | An operation is in progress or is delivering its result |
| doneOut | output | 1 | One-cycle pulse: `resultOut` is valid |
| resultOut | output | 64 | Quotient or remainder |

## Verification
The hardest situations to reach from the ports are the word-mode ones. The operand's upper half must be ignored while the result's upper half must still be set. The stimulus therefore fills bits 63:32 with nonzero patterns, while the low words trigger the unsigned sign-extension, the zero-divisor case and the 32-bit overflow case. A start issued in the middle of a long run checks that the in-flight operands are left alone. Pseudo-random operand pairs of mixed signs and both widths, scored against an independent arithmetic model, cover the sign-correction paths.

// File: rtl/div_rem_pkg.sv
package div_rem_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadOps;      // capture operands, signs and magnitudes
    logic loadSpecial;  // write the fixed special-case result
    logic iterate;      // one shift-subtract step
    logic finalize;     // sign-correct and write the result
  } divStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divState_t;

endpackage

// File: rtl/div_rem_datapath.sv
module div_rem_datapath
  import div_rem_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  divStrobe_t      strobes,
  input  logic [1:0]      funcSel,
  input  logic            wordMode,
  input  logic [XLEN-1:0] dividendIn,
  input  logic [XLEN-1:0] divisorIn,
  output logic            specialHit,
  output logic [XLEN-1:0] resultOut
);

  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] FULL_MIN = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] WORD_MIN = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};

  // Operand view: word mode keeps only the low half, extended per signedness
  logic            opSigned, opIsRem;
  logic [XLEN-1:0] aExt, bExt, aMag, bMag;
  logic            aNeg, bNeg, divZero, divOvf;
  logic [XLEN-1:0] specRaw;

  assign opIsRem  = funcSel[1];
  assign opSigned = !funcSel[0];

  always_comb begin
    if (wordMode) begin
      aExt = {{HALF{opSigned & dividendIn[HALF-1]}}, dividendIn[HALF-1:0]};
      bExt = {{HALF{opSigned & divisorIn[HALF-1]}},  divisorIn[HALF-1:0]};
    end else begin
      aExt = dividendIn;
      bExt = divisorIn;
    end
    aNeg = opSigned & aExt[XLEN-1];
    bNeg = opSigned & bExt[XLEN-1];
    aMag = aNeg ? (~aExt + 1'b1) : aExt;
    bMag = bNeg ? (~bExt + 1'b1) : bExt;
    divZero = (bExt == '0);
    divOvf  = opSigned && (bExt == '1) &&
              (aExt == (wordMode ? WORD_MIN : FULL_MIN));
    if (divZero) specRaw = opIsRem ? aExt : '1;
    else         specRaw = opIsRem ? '0   : aExt;
  end

  assign specialHit = divZero || divOvf;

  function automatic logic [XLEN-1:0] fitWidth(input logic [XLEN-1:0] v, input logic w);
    return w ? {{HALF{v[HALF-1]}}, v[HALF-1:0]} : v;
  endfunction

  // Iteration state
  logic [XLEN-1:0] quoR, remR, divMagR, resultR;
  logic            isRemR, wordR, negQR, negRR;
  logic [XLEN:0]   shifted, trial;
  logic [XLEN-1:0] quoFix, remFix;

  assign shifted = {remR, quoR[XLEN-1]};
  assign trial   = shifted - {1'b0, divMagR};
  assign quoFix  = negQR ? (~quoR + 1'b1) : quoR;
  assign remFix  = negRR ? (~remR + 1'b1) : remR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoR    <= '0;
      remR    <= '0;
      divMagR <= '0;
      resultR <= '0;
      isRemR  <= 1'b0;
      wordR   <= 1'b0;
      negQR   <= 1'b0;
      negRR   <= 1'b0;
    end else begin
      if (strobes.loadOps) begin
        isRemR  <= opIsRem;
        wordR   <= wordMode;
        negQR   <= aNeg ^ bNeg;
        negRR   <= aNeg;
        divMagR <= bMag;
        remR    <= '0;
        quoR    <= wordMode ? {aMag[HALF-1:0], {HALF{1'b0}}} : aMag;
      end
      if (strobes.loadSpecial)
        resultR <= fitWidth(specRaw, wordMode);
      if (strobes.iterate) begin
        if (!trial[XLEN]) begin
          remR <= trial[XLEN-1:0];
          quoR <= {quoR[XLEN-2:0], 1'b1};
        end else begin
          remR <= shifted[XLEN-1:0];
          quoR <= {quoR[XLEN-2:0], 1'b0};
        end
      end
      if (strobes.finalize)
        resultR <= fitWidth(isRemR ? remFix : quoFix, wordR);
    end
  end

  assign resultOut = resultR;

  // R12: the result only moves when the control asked for a write
  a_r12_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultR) |-> $past(strobes.loadSpecial || strobes.finalize));

  // R4: zero divisor on a quotient yields all ones
  a_r4_zero_quot: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadSpecial && divZero && !opIsRem) |=> (resultR == '1));

  // R10: a busy unit keeps the captured divisor untouched
  a_r10_ops_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadOps |=> $stable(divMagR));

  // R6: signed overflow quotient is the most negative operand value
  a_r6_ovf_quot: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadSpecial && divOvf && !divZero && !opIsRem) |=> resultR[XLEN-1]);

endmodule

// File: rtl/div_rem_ctrl.sv
module div_rem_ctrl
  import div_rem_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       wordMode,
  input  logic       specialHit,
  output divStrobe_t strobes,
  output logic       busyOut,
  output logic       doneOut
);

  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN + 1);

  divState_t     state;
  logic [CW-1:0] iterLeft;
  logic          doneR;
  logic          accept;

  assign accept  = startIn && (state == ST_IDLE) && !doneR;
  assign busyOut = (state != ST_IDLE) || doneR;
  assign doneOut = doneR;

  always_comb begin
    strobes             = '0;
    strobes.loadOps     = accept;
    strobes.loadSpecial = accept && specialHit;
    strobes.iterate     = (state == ST_RUN);
    strobes.finalize    = (state == ST_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      iterLeft <= '0;
      doneR    <= 1'b0;
    end else begin
      doneR <= strobes.loadSpecial || strobes.finalize;
      unique case (state)
        ST_IDLE: begin
          if (accept && !specialHit) begin
            state    <= ST_RUN;
            iterLeft <= wordMode ? CW'(HALF) : CW'(XLEN);
          end
        end
        ST_RUN: begin
          iterLeft <= iterLeft - 1'b1;
          if (iterLeft == CW'(1)) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> !doneR);

  // R9: special cases report on the next cycle
  a_r9_special_done: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSpecial |=> doneR);

  // R9: the step counter stays inside its range while running
  a_r9_iter_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (iterLeft != '0 && iterLeft <= CW'(XLEN)));

  // R9: the last step leads to the finishing cycle
  a_r9_run_to_fin: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && iterLeft == CW'(1)) |=> (state == ST_FIN));

endmodule

// File: rtl/div_rem_unit.sv
module div_rem_unit
  import div_rem_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startIn,
  input  logic [1:0]      funcSel,
  input  logic            wordMode,
  input  logic [XLEN-1:0] dividendIn,
  input  logic [XLEN-1:0] divisorIn,
  output logic            busyOut,
  output logic            doneOut,
  output logic [XLEN-1:0] resultOut
);

  divStrobe_t strobes;
  logic       specialHit;

  div_rem_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startIn    (startIn),
    .wordMode   (wordMode),
    .specialHit (specialHit),
    .strobes    (strobes),
    .busyOut    (busyOut),
    .doneOut    (doneOut)
  );

  div_rem_datapath #(.XLEN(XLEN)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .funcSel    (funcSel),
    .wordMode   (wordMode),
    .dividendIn (dividendIn),
    .divisorIn  (divisorIn),
    .specialHit (specialHit),
    .resultOut  (resultOut)
  );

  // R10: a start seen while busy never begins a new capture
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && startIn) |-> !strobes.loadOps);

endmodule

// File: tb/div_rem_unit_tb.sv
`timescale 1ns/1ps
module div_rem_unit_tb;

  typedef struct {
    logic [63:0] expRes;
    int          expLat;
    int          startCyc;
    string       tag;
  } sbItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [1:0]  funcSel = 2'b00;
  logic        wordMode = 1'b0;
  logic [63:0] dividendIn = '0;
  logic [63:0] divisorIn = '0;
  logic        busyOut, doneOut;
  logic [63:0] resultOut;

  int      total = 0;
  int      bad = 0;
  int      cyc = 0;
  bit      prevDone = 1'b0;
  sbItem_t sbQ[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  div_rem_unit u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .funcSel(funcSel),
    .wordMode(wordMode), .dividendIn(dividendIn), .divisorIn(divisorIn),
    .busyOut(busyOut), .doneOut(doneOut), .resultOut(resultOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Independent arithmetic model; fs[1]=remainder, fs[0]=unsigned
  function automatic logic [63:0] refModel(input logic [63:0] a, input logic [63:0] b,
                                           input logic [1:0] fs, input bit w);
    logic [31:0] a32, b32, r32;
    logic [63:0] r64;
    bit sgn;
    sgn = !fs[0];
    if (w) begin
      a32 = a[31:0]; b32 = b[31:0];
      if (b32 == 0) r32 = fs[1] ? a32 : 32'hFFFF_FFFF;
      else if (sgn && a32 == 32'h8000_0000 && b32 == 32'hFFFF_FFFF) r32 = fs[1] ? 32'h0 : a32;
      else if (sgn) r32 = fs[1] ? 32'($signed(a32) % $signed(b32)) : 32'($signed(a32) / $signed(b32));
      else r32 = fs[1] ? a32 % b32 : a32 / b32;
      return {{32{r32[31]}}, r32};
    end
    if (b == 0) r64 = fs[1] ? a : '1;
    else if (sgn && a == 64'h8000_0000_0000_0000 && b == '1) r64 = fs[1] ? 64'h0 : a;
    else if (sgn) r64 = fs[1] ? 64'($signed(a) % $signed(b)) : 64'($signed(a) / $signed(b));
    else r64 = fs[1] ? a % b : a / b;
    return r64;
  endfunction

  function automatic bit isSpecial(input logic [63:0] a, input logic [63:0] b,
                                   input logic [1:0] fs, input bit w);
    if (w) return (b[31:0] == 0) || (!fs[0] && a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF);
    return (b == 0) || (!fs[0] && a == 64'h8000_0000_0000_0000 && b == '1);
  endfunction

  // Driver: waits for idle, pulses start, pushes the expectation
  task automatic doOp(input logic [63:0] a, input logic [63:0] b, input logic [1:0] fs,
                      input bit w, input string tag);
    sbItem_t it;
    @(negedge clk);
    while (busyOut) @(negedge clk);
    dividendIn = a; divisorIn = b; funcSel = fs; wordMode = w; startIn = 1'b1;
    it.expRes   = refModel(a, b, fs, w);
    it.expLat   = isSpecial(a, b, fs, w) ? 0 : (w ? 33 : 65);
    it.startCyc = cyc + 1;
    it.tag      = tag;
    sbQ.push_back(it);
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (busyOut || sbQ.size() != 0) @(negedge clk);
  endtask

  // Monitor: scores every done pulse against the queue head
  always @(negedge clk) begin
    if (rstN) begin
      if (doneOut && prevDone) chk(1'b0, "R10 done wider than one cycle", 64'(doneOut), 64'd0);
      if (doneOut) begin
        if (sbQ.size() == 0) chk(1'b0, "R10 unexpected done", resultOut, 64'd0);
        else begin
          sbItem_t it;
          it = sbQ.pop_front();
          chk(resultOut === it.expRes, it.tag, resultOut, it.expRes);
          chk((cyc - it.startCyc) == it.expLat, {"R9 latency ", it.tag},
              64'(cyc - it.startCyc), 64'(it.expLat));
        end
      end
    end
    prevDone = doneOut;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  initial begin
    logic [63:0] lfsrA, lfsrB, held;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busyOut === 1'b0, "R11 busy after reset", 64'(busyOut), 64'd0);
    chk(doneOut === 1'b0, "R11 done after reset", 64'(doneOut), 64'd0);
    chk(resultOut === 64'd0, "R11 result after reset", resultOut, 64'd0);
    rstN = 1'b1;

    doOp(64'd100, 64'd7, 2'b00, 0, "R1 100/7");
    doOp(-64'sd100, 64'd7, 2'b00, 0, "R1 -100/7");
    doOp(64'd100, -64'sd7, 2'b00, 0, "R1 100/-7");
    doOp(-64'sd100, 64'd7, 2'b10, 0, "R3 -100 rem 7");
    doOp(64'd100, -64'sd7, 2'b10, 0, "R3 100 rem -7");
    doOp(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 2'b01, 0, "R2 unsigned quotient");
    doOp(64'hFFFF_FFFF_FFFF_FFFF, 64'd10, 2'b11, 0, "R2 unsigned remainder");
    doOp(64'h1234_5678_9ABC_DEF0, 64'd0, 2'b00, 0, "R4 signed /0");
    doOp(64'h1234_5678_9ABC_DEF0, 64'd0, 2'b01, 0, "R4 unsigned /0");
    doOp(-64'sd55, 64'd0, 2'b10, 0, "R5 signed rem 0");
    doOp(64'hF000_0000_0000_0001, 64'd0, 2'b11, 0, "R5 unsigned rem 0");
    doOp(MIN64, '1, 2'b00, 0, "R6 overflow quotient");
    doOp(MIN64, '1, 2'b10, 0, "R6 overflow remainder");
    doOp(MIN64, '1, 2'b01, 0, "R2 unsigned min/allones");
    doOp(64'hDEAD_BEEF_0000_0064, 64'h1234_5678_0000_0007, 2'b00, 1, "R7 word upper ignored");
    doOp(64'hAAAA_AAAA_FFFF_FF9C, 64'h5555_5555_0000_0007, 2'b10, 1, "R7 word rem upper ignored");
    doOp(64'h0000_0000_FFFF_FFFE, 64'd1, 2'b01, 1, "R8 DIVUW sign extension");
    doOp(64'h1111_1111_FFFF_FFFF, 64'h2222_2222_8000_0000, 2'b11, 1, "R8 REMUW sign extension");
    doOp(64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0000, 2'b11, 1, "R8 word zero divisor remainder");
    doOp(64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 2'b00, 1, "R8 word overflow");
    doOp(64'h0000_0001_0000_0005, 64'h0000_0007_0000_0000, 2'b01, 1, "R8 word zero divisor quotient");

    lfsrA = 64'hACE1_2345_6789_BEEF;
    lfsrB = 64'h0F0F_1234_8001_0003;
    for (int i = 0; i < 16; i++) begin
      lfsrA = {lfsrA[62:0], lfsrA[63] ^ lfsrA[62] ^ lfsrA[60] ^ lfsrA[59]};
      lfsrB = {lfsrB[62:0], lfsrB[63] ^ lfsrB[62] ^ lfsrB[60] ^ lfsrB[59]};
      doOp(lfsrA, (i % 3 == 0) ? (lfsrB >> 40) : lfsrB, 2'(i), i[2],
           (i % 2 == 0) ? "R1 random mix" : "R2 random mix");
    end
    drain();

    // R10: a start during a run is ignored
    doOp(64'd1000, 64'd9, 2'b00, 0, "R10 first op kept");
    repeat (5) @(negedge clk);
    dividendIn = 64'd77; divisorIn = 64'd0; funcSel = 2'b11; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    drain();
    repeat (70) @(negedge clk);
    chk(sbQ.size() == 0 && !busyOut, "R10 no extra operation", 64'(busyOut), 64'd0);

    // R12: result holds while idle and during the next run
    held = resultOut;
    repeat (10) @(negedge clk);
    chk(resultOut === held, "R12 hold while idle", resultOut, held);
    doOp(64'd500, 64'd3, 2'b00, 0, "R12 next op");
    repeat (20) @(negedge clk);
    chk(resultOut === held, "R12 hold during run", resultOut, held);
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule